// File: doc/BRIEF.md
# Periodic ADC Update Scheduler

This block paces an 8-bit successive-approximation converter so that a result register is refreshed on a fixed period. A two-bit channel field either parks the converter (value 00) or picks one of three analog inputs. When the converter is switched on, a first result arrives after a short start-up delay. After that, results arrive once per period. The analog comparator is outside the block. The block drives the mux select and the trial code, and it reads back one comparator bit per trial.

Before each scheduled write, a status flag rises a fixed number of clock ticks early. A host that sees the flag low knows the register will hold still for at least that long. A host read is signalled by a read-cycle input together with chip-select. While both are high, the register is frozen. A result that completes during a read is parked and lands in the first cycle after the lock drops. Dropping chip-select aborts the read.

Top module: `adc_update_sched`

## Requirements
- R1: While `ch_sel` is 00 the converter is idle: `upd_pending` is 0, `mux_sel` is 00, `trial_code` is 0 and `result` does not change.
- R2: On the clock edge where `ch_sel` first turns non-zero after being 00, a timer starts, and the first result is written exactly FIRST_TICKS edges later.
- R3: After the first write, scheduled writes follow every PERIOD_TICKS edges.
- R4: A change of `ch_sel` while running does not restart the timer. The new channel is latched DATA_W edges before the next scheduled write and shows on `mux_sel` (01, 10, 11 map to inputs 1, 2, 3).
- R5: `upd_pending` rises exactly WARN_TICKS cycles before a scheduled write and clears on the edge that writes `result`. `result` never changes unless `upd_pending` was 1 in the preceding cycle.
- R6: While `rd_cycle` and `cs` are both 1, `result` does not change.
- R7: Taking `cs` low ends the lock, even while `rd_cycle` stays high.
- R8: A result finished under the lock is held back, with `upd_pending` staying 1. It is written on the first edge at which the lock is released, and the flag then clears.
- R9: The conversion tests bits from MSB to LSB, one per cycle, and keeps a bit when `cmp_hi` is 1 (input at or above the trial code). A full-scale input yields FFh and ground yields 00h.
- R10: After synchronous reset, `result` is 00h, `upd_pending` is 0 and `mux_sel` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_sel | input | 2 | Channel field; 00 = off, 01/10/11 = input 1/2/3 |
| cmp_hi | input | 1 | Comparator: 1 when the selected input is at or above `trial_code` |
| rd_cycle | input | 1 | Host read of the result register in progress |
| cs | input | 1 | Chip-select; low aborts a read |
| mux_sel | output | 2 | Channel driven to the analog mux for the current conversion |
| trial_code | output | 8 | SAR trial level sent to the DAC/comparator |
| upd_pending | output | 1 | Advance warning that a result write is imminent |
| result | output | 8 | Result register |

## Verification
Every result is due at a fixed edge count from a stimulus. The first write comes FIRST_TICKS edges after the enabling edge. Each later write comes PERIOD_TICKS edges after the previous one. The flag leads each write by WARN_TICKS cycles. A held-back result lands one edge after the lock drops.

The bench drives inputs on falling edges. A behavioural model updates on rising edges by counting edges since enable. Outputs are compared on the next falling edge, so each expected value is taken just after the edge that should produce it. Directed checks count falling edges from the driving edge: the first result is expected at count FIRST_TICKS+1, and a released write is expected at the next falling edge.

// File: rtl/adc_sched_pkg.sv
package adc_sched_pkg;
  typedef logic [1:0] chan_t;
  localparam chan_t CH_OFF = 2'b00;
endpackage

// File: rtl/adc_slot_timer.sv
module adc_slot_timer #(
  parameter int PERIOD_TICKS = 100,
  parameter int FIRST_TICKS  = 20,
  parameter int WARN_TICKS   = 12,
  parameter int DATA_W       = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic on,
  output logic run,
  output logic warn_hit,
  output logic conv_start,
  output logic slot_hit
);
  localparam int MAXT = (PERIOD_TICKS > FIRST_TICKS) ? PERIOD_TICKS : FIRST_TICKS;
  localparam int CW   = $clog2(MAXT + 1);

  logic          on_q;
  logic [CW-1:0] cnt;

  // cnt holds the edges left until the next write slot
  always_ff @(posedge clk) begin
    if (rst) begin
      on_q <= 1'b0;
      cnt  <= '0;
    end else begin
      on_q <= on;
      if (on && !on_q)
        cnt <= CW'(FIRST_TICKS - 1);
      else if (on && on_q)
        cnt <= (cnt == '0) ? CW'(PERIOD_TICKS - 1) : cnt - 1'b1;
    end
  end

  assign run        = on && on_q;
  assign warn_hit   = run && (cnt == CW'(WARN_TICKS));
  assign conv_start = run && (cnt == CW'(DATA_W));
  assign slot_hit   = run && (cnt == '0);
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core
  import adc_sched_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              start,
  input  chan_t             sel,
  input  logic              cmp_hi,
  output chan_t             chan,
  output logic [DATA_W-1:0] trial,
  output logic              done,
  output logic [DATA_W-1:0] final_code
);
  localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic              busy;
  logic [IW-1:0]     idx;
  logic [DATA_W-1:0] kept;

  // keep the bit under test only when the input is at or above the trial level
  assign kept       = cmp_hi ? trial : (trial & ~(DATA_W'(1) << idx));
  assign done       = busy && (idx == '0);
  assign final_code = kept;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      busy  <= 1'b0;
      idx   <= '0;
      trial <= '0;
      chan  <= CH_OFF;
    end else if (start) begin
      busy  <= 1'b1;
      idx   <= IW'(DATA_W - 1);
      trial <= DATA_W'(1) << (DATA_W - 1);
      chan  <= sel;
    end else if (busy) begin
      if (idx == '0) begin
        busy  <= 1'b0;
        trial <= '0;
      end else begin
        trial <= kept | (DATA_W'(1) << (idx - 1'b1));
        idx   <= idx - 1'b1;
      end
    end
  end

  AST_SAR_ONE_HOT_START: assert property (@(posedge clk) disable iff (rst)
    (run && start) |=> ($countones(trial) == 1 && trial[DATA_W-1])); // R9
endmodule

// File: rtl/adc_result_hold.sv
module adc_result_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              done,
  input  logic [DATA_W-1:0] fin,
  input  logic              warn_hit,
  input  logic              rd_cycle,
  input  logic              cs,
  output logic [DATA_W-1:0] result,
  output logic              flag
);
  logic              lock;
  logic              pend_v;
  logic [DATA_W-1:0] pend;

  assign lock = rd_cycle && cs;

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      flag   <= 1'b0;
      pend_v <= 1'b0;
      pend   <= '0;
    end else if (!run) begin
      flag   <= 1'b0;
      pend_v <= 1'b0;
    end else begin
      if (done) begin
        if (lock) begin
          pend   <= fin;
          pend_v <= 1'b1;
        end else begin
          result <= fin;
          pend_v <= 1'b0;
          flag   <= 1'b0;
        end
      end else if (pend_v && !lock) begin
        result <= pend;
        pend_v <= 1'b0;
        flag   <= 1'b0;
      end
      if (warn_hit)
        flag <= 1'b1;
    end
  end

  AST_NO_WRITE_LOCKED: assert property (@(posedge clk) disable iff (rst)
    lock |=> $stable(result)); // R6
  AST_WRITE_AFTER_WARN: assert property (@(posedge clk) disable iff (rst)
    !$stable(result) |-> $past(flag)); // R5
endmodule

// File: rtl/adc_update_sched.sv
module adc_update_sched
  import adc_sched_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int PERIOD_TICKS = 100,
  parameter int FIRST_TICKS  = 20,
  parameter int WARN_TICKS   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        ch_sel,
  input  logic              cmp_hi,
  input  logic              rd_cycle,
  input  logic              cs,
  output logic [1:0]        mux_sel,
  output logic [DATA_W-1:0] trial_code,
  output logic              upd_pending,
  output logic [DATA_W-1:0] result
);
  // ordering needed: DATA_W <= WARN_TICKS < FIRST_TICKS, DATA_W < PERIOD_TICKS
  logic              on, run, warn_hit, conv_start, slot_hit, done;
  logic [DATA_W-1:0] fin;
  chan_t             chan;

  assign on = (ch_sel != CH_OFF);

  adc_slot_timer #(
    .PERIOD_TICKS(PERIOD_TICKS), .FIRST_TICKS(FIRST_TICKS),
    .WARN_TICKS(WARN_TICKS), .DATA_W(DATA_W)
  ) u_timer (
    .clk(clk), .rst(rst), .on(on), .run(run), .warn_hit(warn_hit),
    .conv_start(conv_start), .slot_hit(slot_hit)
  );

  adc_sar_core #(.DATA_W(DATA_W)) u_sar (
    .clk(clk), .rst(rst), .run(run), .start(conv_start), .sel(ch_sel),
    .cmp_hi(cmp_hi), .chan(chan), .trial(trial_code), .done(done),
    .final_code(fin)
  );

  adc_result_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .run(run), .done(done), .fin(fin),
    .warn_hit(warn_hit), .rd_cycle(rd_cycle), .cs(cs),
    .result(result), .flag(upd_pending)
  );

  assign mux_sel = chan;

  AST_SLOT_MEETS_DONE: assert property (@(posedge clk) disable iff (rst)
    slot_hit |-> done); // R3
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    !on |=> (!upd_pending && mux_sel == CH_OFF && trial_code == '0)); // R1
endmodule

// File: tb/adc_update_sched_test.sv
module adc_update_sched_test;
  localparam int W = 8, PER = 100, FIRST = 20, WARN = 12;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] ch_sel = 2'b00;
  logic rd_cycle = 1'b0, cs = 1'b0;
  logic [1:0] mux_sel;
  logic [W-1:0] trial_code, result;
  logic upd_pending, cmp_hi;
  logic [W-1:0] ana [4];

  int checks = 0, fails = 0, cyc = 0;
  always #5 clk = ~clk;

  assign cmp_hi = (ana[mux_sel] >= trial_code);

  adc_update_sched #(.DATA_W(W), .PERIOD_TICKS(PER), .FIRST_TICKS(FIRST),
                     .WARN_TICKS(WARN)) uut (
    .clk(clk), .rst(rst), .ch_sel(ch_sel), .cmp_hi(cmp_hi),
    .rd_cycle(rd_cycle), .cs(cs), .mux_sel(mux_sel), .trial_code(trial_code),
    .upd_pending(upd_pending), .result(result));

  // behavioural reference: edges since enable, next due edge, parked value
  int age, due, m_res, m_flag, m_pend_v, m_pend, m_chan, conv_chan;
  bit was_on;
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      was_on = 0; m_res = 0; m_flag = 0; m_pend_v = 0; m_chan = 0;
    end else begin
      bit on_n, lk;
      on_n = (ch_sel != 2'b00);
      lk   = rd_cycle && cs;
      if (!(on_n && was_on)) begin
        m_flag = 0; m_pend_v = 0; m_chan = 0;
        if (on_n) begin age = 0; due = FIRST; end
      end else begin
        age++;
        if (age == due - W) begin conv_chan = ch_sel; m_chan = ch_sel; end
        if (age == due) begin
          if (lk) begin m_pend = ana[conv_chan]; m_pend_v = 1; end
          else begin m_res = ana[conv_chan]; m_pend_v = 0; m_flag = 0; end
          due += PER;
        end else if (m_pend_v && !lk) begin
          m_res = m_pend; m_pend_v = 0; m_flag = 0;
        end
        if (age == due - WARN) m_flag = 1;
      end
      was_on = on_n;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk(result == W'(m_res), "R3 result", result, m_res);
      chk(upd_pending == m_flag[0], "R5 flag", upd_pending, m_flag);
      chk(mux_sel == 2'(m_chan), "R4 mux_sel", mux_sel, m_chan);
      if (!was_on) chk(trial_code == '0, "R1 trial idle", trial_code, 0);
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic wait_flag(input bit v);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (upd_pending == v) return;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    summary();
  end

  initial begin
    int n, t1, t2;
    ana[0] = 8'h00; ana[1] = 8'h5A; ana[2] = 8'h00; ana[3] = 8'hFF;
    repeat (3) @(negedge clk);
    chk(result == 8'h00, "R10 result", result, 0);
    chk(upd_pending == 1'b0, "R10 flag", upd_pending, 0);
    chk(mux_sel == 2'b00, "R10 mux", mux_sel, 0);
    rst = 1'b0;
    @(negedge clk);

    // R2: first write; drive edge counts as 1 so the write is seen at FIRST+1
    ch_sel = 2'b01;
    n = 0;
    while (result == 8'h00 && n < 60) begin @(negedge clk); n++; end
    chk(n == FIRST + 1, "R2 first write delay", n, FIRST + 1);
    chk(result == 8'h5A, "R9 code", result, 8'h5A);

    // R5 warning length and R3 period
    wait_flag(1'b1);
    n = 0;
    while (upd_pending && n < 100) begin @(negedge clk); n++; end
    chk(n == WARN, "R5 warn length", n, WARN);
    t1 = cyc;
    ch_sel = 2'b11;               // R4: change mid-period
    repeat (30) @(negedge clk);
    chk(result == 8'h5A, "R4 no early effect", result, 8'h5A);
    wait_flag(1'b1); wait_flag(1'b0);
    t2 = cyc;
    chk(t2 - t1 == PER, "R3 period kept", t2 - t1, PER);
    chk(result == 8'hFF, "R9 full scale", result, 8'hFF);

    // R6/R7/R8: lock over a write, released by cs low
    ch_sel = 2'b10;
    wait_flag(1'b1);
    rd_cycle = 1'b1; cs = 1'b1;
    repeat (WARN + 10) @(negedge clk);
    chk(result == 8'hFF, "R6 frozen", result, 8'hFF);
    chk(upd_pending == 1'b1, "R8 flag held", upd_pending, 1);
    cs = 1'b0;
    @(negedge clk);
    chk(result == 8'h00, "R7 abort releases", result, 8'h00);
    chk(upd_pending == 1'b0, "R8 flag cleared", upd_pending, 0);

    // R8: release by read end
    ch_sel = 2'b01;
    wait_flag(1'b1);
    cs = 1'b1; rd_cycle = 1'b1;
    repeat (WARN + 5) @(negedge clk);
    chk(result == 8'h00, "R6 frozen again", result, 8'h00);
    rd_cycle = 1'b0;
    @(negedge clk);
    chk(result == 8'h5A, "R8 parked write", result, 8'h5A);
    cs = 1'b0;

    // R1: off
    ch_sel = 2'b00;
    n = 0;
    for (int i = 0; i < 250; i++) begin
      @(negedge clk);
      if (upd_pending || result != 8'h5A) n++;
    end
    chk(n == 0, "R1 idle no activity", n, 0);
    chk(mux_sel == 2'b00, "R1 mux off", mux_sel, 0);

    // new analog levels, re-enable
    ana[1] = 8'h80; ana[2] = 8'h7F; ana[3] = 8'h01;
    ch_sel = 2'b10;
    repeat (FIRST + 1) @(negedge clk);
    chk(result == 8'h7F, "R2 re-enable first write", result, 8'h7F);
    ch_sel = 2'b11;
    repeat (PER) @(negedge clk);
    chk(result == 8'h01, "R9 low code", result, 8'h01);
    ch_sel = 2'b01;
    repeat (PER) @(negedge clk);
    chk(result == 8'h80, "R9 mid code", result, 8'h80);
    repeat (20) @(negedge clk);
    summary();
  end
endmodule